// File: doc/BRIEF.md
# Multicycle Load-Store Execution Sequencer

This block sequences a simple non-pipelined 32-bit integer core through its per-instruction stages. It also carries out that core's memory accesses. A stage counter fetches an instruction word from a synchronous RAM. It then hands the word to decode and execute. Loads and stores get one more stage, so the one-cycle RAM read latency can be absorbed or the write can be issued. Every other instruction finishes after execute. Arithmetic, branch and control behaviour sit outside this block; here they only affect the stage count and the program counter step.

During execute the block builds a 10-bit operation identifier from the 3-bit function field and the 7-bit opcode. For memory operations it adds the base register to the sign-extended 12-bit offset. A load issues a word read and, one cycle later, selects the addressed byte or halfword, extends it and writes it to the register write port. A store replicates its data across the byte lanes and drives a byte strobe. The register file and the RAM are outside the block; the block sees the register file through two combinational read ports and one write port.

Top module: `mcyc_lsu_seq`

## Requirements
- R1: While reset is asserted and directly after it is released, `pc_o` equals the `RESET_PC` parameter (default 0) and `stage_o` is 0 (fetch).
- R2: In stage 0 the block drives `mem_re`=1 with `mem_addr` equal to `pc_o`. The returned word is the instruction that stage 1 decodes.
- R3: An instruction whose operation identifier is not a listed load or store takes exactly two cycles (stage 0, stage 1). It causes no register write and no memory write. This includes opcode 0000011 or 0100011 with an unlisted function field.
- R4: A load takes exactly three cycles. In stage 1 it reads the word that holds the effective address, rs1 + sign-extended imm[11:0] (instruction bits 31:20), and the offset may be negative. In stage 2 it writes the result to register rd (instruction bits 11:7).
- R5: The operation identifier is {funct3 (bits 14:12), opcode (bits 6:0)}. Loads: 000_0000011 signed byte, 001_0000011 signed halfword, 010_0000011 word, 100_0000011 unsigned byte, 101_0000011 unsigned halfword. Stores: 000_0100011 byte, 001_0100011 halfword, 010_0100011 word.
- R6: A byte load takes byte lane addr[1:0] (lane n = data bits 8n+7:8n). A halfword load takes bits 31:16 when addr[1]=1 and bits 15:0 otherwise. Signed forms copy the top bit into the upper bits; unsigned forms fill them with zeros.
- R7: A store takes exactly three cycles. It writes to memory only in stage 2, with no register write and no read in the same cycle. The offset is {bits 31:25, bits 11:7}, sign-extended. A byte store writes rs2[7:0] to lane addr[1:0] only. A halfword store writes rs2[15:0] to lanes 1:0 or 3:2 as chosen by addr[1]. A word store writes all four lanes.
- R8: A load whose rd is register 0 never asserts the register write port, and it still takes three cycles.
- R9: `retire_o` is high for exactly one cycle per instruction, in its last stage, and `pc_o` then advances by 4. It is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_re | output | 1 | Memory read request; data returns on the next cycle |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the accessed word (low two bits zero for data accesses) |
| mem_wstrb | output | 4 | Byte-lane write strobe |
| mem_wdata | output | 32 | Write data, lane-replicated |
| mem_rdata | input | 32 | Read data from the previous cycle's request |
| rs1_idx | output | 5 | Base register index |
| rs2_idx | output | 5 | Store data register index |
| rs1_val | input | 32 | Base register value |
| rs2_val | input | 32 | Store data register value |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| pc_o | output | 32 | Program counter |
| stage_o | output | 2 | Current stage: 0 fetch, 1 execute, 2 memory |
| retire_o | output | 1 | High in the last stage of each instruction |

## Verification
The hardest case to reach from the ports is a sign bit in each byte and halfword position, read at the right lane only after the one-cycle RAM delay. A second hard case is a load that targets register 0 while still taking its full third stage. The bench keeps a word of four distinct byte values in its RAM model, including bytes with the top bit set and clear. It runs every load width at several offsets against that word and plants each instruction at the exact address the counter is about to fetch. Stores are checked by reading the RAM model afterwards. Lanes outside the strobe must keep their old contents.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int XLEN    = 32;
  localparam int NBYTES  = XLEN / 8;
  localparam int OFF_W   = $clog2(NBYTES);
  localparam int REG_AW  = 5;
  localparam int IMM_W   = 12;
  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int OPID_W  = F3_W + OPC_W;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_MEM   = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef struct packed {
    logic  is_load;
    logic  is_store;
    size_e size;
    logic  zext;
  } memop_t;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;

  localparam logic [OPID_W-1:0] OPID_LD_B  = {3'b000, OPC_LOAD};
  localparam logic [OPID_W-1:0] OPID_LD_H  = {3'b001, OPC_LOAD};
  localparam logic [OPID_W-1:0] OPID_LD_W  = {3'b010, OPC_LOAD};
  localparam logic [OPID_W-1:0] OPID_LD_BU = {3'b100, OPC_LOAD};
  localparam logic [OPID_W-1:0] OPID_LD_HU = {3'b101, OPC_LOAD};
  localparam logic [OPID_W-1:0] OPID_ST_B  = {3'b000, OPC_STORE};
  localparam logic [OPID_W-1:0] OPID_ST_H  = {3'b001, OPC_STORE};
  localparam logic [OPID_W-1:0] OPID_ST_W  = {3'b010, OPC_STORE};
endpackage

// File: rtl/lsq_decode.sv
module lsq_decode
  import lsq_pkg::*;
(
  input  logic [XLEN-1:0]   instr,
  output memop_t            op,
  output logic [REG_AW-1:0] rs1,
  output logic [REG_AW-1:0] rs2,
  output logic [REG_AW-1:0] rd,
  output logic [XLEN-1:0]   imm
);
  logic [OPID_W-1:0] opid;
  logic [XLEN-1:0]   imm_load;
  logic [XLEN-1:0]   imm_store;

  assign opid      = {instr[14:12], instr[6:0]};
  assign rs1       = instr[19:15];
  assign rs2       = instr[24:20];
  assign rd        = instr[11:7];
  assign imm_load  = {{(XLEN-IMM_W){instr[31]}}, instr[31:20]};
  assign imm_store = {{(XLEN-IMM_W){instr[31]}}, instr[31:25], instr[11:7]};

  // R5: operation identifier table
  always_comb begin
    op = '0;
    case (opid)
      OPID_LD_B:  begin op.is_load  = 1'b1; op.size = SZ_BYTE; end
      OPID_LD_H:  begin op.is_load  = 1'b1; op.size = SZ_HALF; end
      OPID_LD_W:  begin op.is_load  = 1'b1; op.size = SZ_WORD; end
      OPID_LD_BU: begin op.is_load  = 1'b1; op.size = SZ_BYTE; op.zext = 1'b1; end
      OPID_LD_HU: begin op.is_load  = 1'b1; op.size = SZ_HALF; op.zext = 1'b1; end
      OPID_ST_B:  begin op.is_store = 1'b1; op.size = SZ_BYTE; end
      OPID_ST_H:  begin op.is_store = 1'b1; op.size = SZ_HALF; end
      OPID_ST_W:  begin op.is_store = 1'b1; op.size = SZ_WORD; end
      default:    op = '0;
    endcase
  end

  assign imm = op.is_store ? imm_store : imm_load;
endmodule

// File: rtl/lsq_stage_ctrl.sv
module lsq_stage_ctrl
  import lsq_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int              PC_STEP  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_op,
  output stage_e          stage,
  output logic [XLEN-1:0] pc,
  output logic            retire
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  stage_e          stage_d;
  logic [XLEN-1:0] pc_d;
  logic            pc_en;

  always_comb begin
    stage_d = stage;
    retire  = 1'b0;
    case (stage)
      ST_FETCH: stage_d = ST_EXEC;
      ST_EXEC: begin
        if (mem_op) begin
          stage_d = ST_MEM;
        end else begin
          stage_d = ST_FETCH;
          retire  = 1'b1;
        end
      end
      ST_MEM: begin
        stage_d = ST_FETCH;
        retire  = 1'b1;
      end
      default: stage_d = ST_FETCH;
    endcase
    pc_en = retire;
    pc_d  = pc + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= ST_FETCH;
      pc    <= RESET_PC;
    end else begin
      stage <= stage_d;
      if (pc_en) pc <= pc_d;
    end
  end

  a_r3_fetch_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_FETCH) |=> (stage == ST_EXEC));
  a_r3_plain_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_EXEC && !mem_op) |=> (stage == ST_FETCH));
  a_r4_mem_follows_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_MEM) |-> ($past(stage) == ST_EXEC));
  a_r9_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (pc == $past(pc) + STEP));
  a_r9_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(pc));
endmodule

// File: rtl/lsq_load_ext.sv
module lsq_load_ext
  import lsq_pkg::*;
(
  input  logic [XLEN-1:0]  word,
  input  logic [OFF_W-1:0] off,
  input  size_e            size,
  input  logic             zext,
  output logic [XLEN-1:0]  value
);
  logic [OFF_W-1:0] half_off;
  logic [XLEN-1:0]  byte_sh;
  logic [XLEN-1:0]  half_sh;
  logic             fill;

  // R6: byte lane by off, halfword by upper offset bits
  assign half_off = {off[OFF_W-1:1], 1'b0};
  assign byte_sh  = word >> {off, 3'b000};
  assign half_sh  = word >> {half_off, 3'b000};

  always_comb begin
    value = word;
    fill  = 1'b0;
    case (size)
      SZ_BYTE: begin
        fill  = !zext && byte_sh[7];
        value = {{(XLEN-8){fill}}, byte_sh[7:0]};
      end
      SZ_HALF: begin
        fill  = !zext && half_sh[15];
        value = {{(XLEN-16){fill}}, half_sh[15:0]};
      end
      default: value = word;
    endcase
  end
endmodule

// File: rtl/lsq_store_lane.sv
module lsq_store_lane
  import lsq_pkg::*;
(
  input  logic [XLEN-1:0]   data,
  input  logic [OFF_W-1:0]  off,
  input  size_e             size,
  output logic [XLEN-1:0]   wdata,
  output logic [NBYTES-1:0] wstrb
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    localparam int               HSEL = g % 2;
    localparam logic [OFF_W-1:0] LANE = OFF_W'(g);
    logic [7:0] lane_d;
    logic       lane_s;

    // R7: lane replication and strobe per access size
    always_comb begin
      case (size)
        SZ_BYTE: begin
          lane_d = data[7:0];
          lane_s = (off == LANE);
        end
        SZ_HALF: begin
          lane_d = data[HSEL*8 +: 8];
          lane_s = (off[OFF_W-1:1] == LANE[OFF_W-1:1]);
        end
        default: begin
          lane_d = data[g*8 +: 8];
          lane_s = 1'b1;
        end
      endcase
    end

    assign wdata[g*8 +: 8] = lane_d;
    assign wstrb[g]        = lane_s;
  end
endmodule

// File: rtl/mcyc_lsu_seq.sv
module mcyc_lsu_seq
  import lsq_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_re,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_wstrb,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic [4:0]  rs1_idx,
  output logic [4:0]  rs2_idx,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  output logic        rf_we,
  output logic [4:0]  rf_waddr,
  output logic [31:0] rf_wdata,
  output logic [31:0] pc_o,
  output logic [1:0]  stage_o,
  output logic        retire_o
);
  stage_e            stage;
  logic [XLEN-1:0]   pc;
  logic              retire;

  memop_t            dec_op;
  logic [REG_AW-1:0] dec_rd;
  logic [XLEN-1:0]   dec_imm;
  logic [XLEN-1:0]   ea;
  logic              dec_mem;
  logic              hold_en;

  logic [XLEN-1:0]   st_wdata;
  logic [NBYTES-1:0] st_wstrb;
  logic [XLEN-1:0]   ld_value;

  memop_t            held_op,    held_op_d;
  logic [XLEN-1:0]   held_addr,  held_addr_d;
  logic [REG_AW-1:0] held_rd,    held_rd_d;
  logic [XLEN-1:0]   held_wdata, held_wdata_d;
  logic [NBYTES-1:0] held_wstrb, held_wstrb_d;

  lsq_decode u_dec (
    .instr (mem_rdata),
    .op    (dec_op),
    .rs1   (rs1_idx),
    .rs2   (rs2_idx),
    .rd    (dec_rd),
    .imm   (dec_imm)
  );

  assign dec_mem = dec_op.is_load || dec_op.is_store;
  assign ea      = rs1_val + dec_imm;
  assign hold_en = (stage == ST_EXEC) && dec_mem;

  lsq_stage_ctrl #(.RESET_PC(RESET_PC), .PC_STEP(4)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_op (dec_mem),
    .stage  (stage),
    .pc     (pc),
    .retire (retire)
  );

  lsq_store_lane u_st (
    .data  (rs2_val),
    .off   (ea[OFF_W-1:0]),
    .size  (dec_op.size),
    .wdata (st_wdata),
    .wstrb (st_wstrb)
  );

  // capture of the memory access for the third stage
  always_comb begin
    held_op_d    = dec_op;
    held_addr_d  = ea;
    held_rd_d    = dec_rd;
    held_wdata_d = st_wdata;
    held_wstrb_d = st_wstrb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_op    <= '0;
      held_addr  <= '0;
      held_rd    <= '0;
      held_wdata <= '0;
      held_wstrb <= '0;
    end else if (hold_en) begin
      held_op    <= held_op_d;
      held_addr  <= held_addr_d;
      held_rd    <= held_rd_d;
      held_wdata <= held_wdata_d;
      held_wstrb <= held_wstrb_d;
    end
  end

  lsq_load_ext u_ld (
    .word  (mem_rdata),
    .off   (held_addr[OFF_W-1:0]),
    .size  (held_op.size),
    .zext  (held_op.zext),
    .value (ld_value)
  );

  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pc;
    mem_wstrb = '0;
    mem_wdata = held_wdata;
    rf_we     = 1'b0;
    case (stage)
      ST_FETCH: mem_re = 1'b1;
      ST_EXEC: begin
        mem_re   = dec_op.is_load;
        mem_addr = {ea[XLEN-1:OFF_W], {OFF_W{1'b0}}};
      end
      ST_MEM: begin
        mem_addr  = {held_addr[XLEN-1:OFF_W], {OFF_W{1'b0}}};
        mem_we    = held_op.is_store;
        mem_wstrb = held_op.is_store ? held_wstrb : '0;
        rf_we     = held_op.is_load && (held_rd != '0);
      end
      default: mem_re = 1'b0;
    endcase
  end

  assign rf_waddr = held_rd;
  assign rf_wdata = ld_value;
  assign pc_o     = pc;
  assign stage_o  = stage;
  assign retire_o = retire;

  a_r8_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != '0));
  a_r7_no_read_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_re);
  a_r7_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_wstrb) == (32'd1 << held_op.size)));
  a_r4_writeback_ends: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> (stage == ST_FETCH));
endmodule

// File: tb/test_mcyc_lsu_seq.sv
module test_mcyc_lsu_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_re, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;
  logic [4:0]  rs1_idx, rs2_idx, rf_waddr;
  logic [31:0] rs1_val, rs2_val, rf_wdata, pc_o;
  logic        rf_we, retire_o;
  logic [1:0]  stage_o;

  logic [31:0] mem [0:63];
  logic [31:0] rf  [0:31];

  int n_tests  = 0;
  int n_failed = 0;
  int last_cyc;
  bit last_rf_we, last_mem_we;

  always #5 clk = ~clk;

  mcyc_lsu_seq i_mcyc_lsu_seq (
    .clk(clk), .rst_n(rst_n),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .pc_o(pc_o), .stage_o(stage_o), .retire_o(retire_o)
  );

  assign rs1_val = rf[rs1_idx];
  assign rs2_val = rf[rs2_idx];

  // RAM and register file models
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[7:2]];
    if (mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_wstrb[b]) mem[mem_addr[7:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
    if (rf_we) rf[rf_waddr] = rf_wdata;
  end

  function automatic logic [31:0] enc_ld(input logic [2:0] f3, input logic [4:0] rd,
                                         input logic [4:0] rs1, input logic [11:0] imm);
    return {imm, rs1, f3, rd, 7'b0000011};
  endfunction

  function automatic logic [31:0] enc_st(input logic [2:0] f3, input logic [4:0] rs2,
                                         input logic [4:0] rs1, input logic [11:0] imm);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // hands one instruction to the fetch of the current pc and runs it to completion
  task automatic run_instr(input logic [31:0] instr, input string req, input int exp_cyc);
    logic [31:0] pc0;
    int retires;
    pc0 = pc_o;
    mem[pc0[7:2]] = instr;
    check(mem_re && mem_addr == pc0, "R2", "fetch address", mem_addr, pc0);
    last_cyc = 0; retires = 0; last_rf_we = 0; last_mem_we = 0;
    do begin
      @(posedge clk); @(negedge clk);
      last_cyc++;
      if (stage_o != 2'd0) begin
        if (rf_we)    last_rf_we  = 1;
        if (mem_we)   last_mem_we = 1;
        if (retire_o) retires++;
      end
    end while (stage_o != 2'd0 && last_cyc < 10);
    check(last_cyc == exp_cyc, req, "cycle count", last_cyc, exp_cyc);
    check(retires == 1, "R9", "retire pulses", retires, 1);
    check(pc_o == pc0 + 4, "R9", "pc step", pc_o, pc0 + 4);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pc_o == 32'h0, "R1", "pc in reset", pc_o, 32'h0);
    check(stage_o == 2'd0, "R1", "stage in reset", {30'h0, stage_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc_o == 32'h0 && stage_o == 2'd1, "R1", "first fetch done", pc_o, 32'h0);
    // realign to a fetch stage: finish the all-zero word fetched at pc 0
    while (stage_o != 2'd0) @(negedge clk);
  endtask

  task automatic t_plain;
    run_instr(32'h0000_0013, "R3", 2);
    check(!last_rf_we && !last_mem_we, "R3", "no writes", {30'h0, last_rf_we, last_mem_we}, 32'h0);
  endtask

  task automatic t_unlisted_funct3;
    rf[16] = 32'h5A;
    run_instr(enc_ld(3'b011, 5'd16, 5'd1, 12'd0), "R3", 2);
    check(rf[16] == 32'h5A && !last_rf_we, "R5", "unlisted load code", rf[16], 32'h5A);
    run_instr(enc_st(3'b011, 5'd6, 5'd2, 12'd0), "R3", 2);
    check(!last_mem_we, "R5", "unlisted store code", {31'h0, last_mem_we}, 32'h0);
  endtask

  task automatic t_word_loads;
    run_instr(enc_ld(3'b010, 5'd17, 5'd9, 12'd4), "R4", 3);
    check(rf[17] == 32'h8BAD_F00D, "R4", "lw positive offset", rf[17], 32'h8BAD_F00D);
    run_instr(enc_ld(3'b010, 5'd5, 5'd4, 12'hFF0), "R4", 3);
    check(rf[5] == 32'h80F1_7F22, "R4", "lw negative offset", rf[5], 32'h80F1_7F22);
  endtask

  task automatic t_byte_loads;
    run_instr(enc_ld(3'b000, 5'd10, 5'd1, 12'd3), "R4", 3);
    check(rf[10] == 32'hFFFF_FF80, "R6", "lb lane3 signed", rf[10], 32'hFFFF_FF80);
    run_instr(enc_ld(3'b000, 5'd11, 5'd1, 12'd1), "R4", 3);
    check(rf[11] == 32'h0000_007F, "R6", "lb lane1 positive", rf[11], 32'h0000_007F);
    run_instr(enc_ld(3'b100, 5'd12, 5'd1, 12'd2), "R4", 3);
    check(rf[12] == 32'h0000_00F1, "R6", "lbu lane2", rf[12], 32'h0000_00F1);
  endtask

  task automatic t_half_loads;
    run_instr(enc_ld(3'b001, 5'd13, 5'd1, 12'd2), "R4", 3);
    check(rf[13] == 32'hFFFF_80F1, "R6", "lh upper signed", rf[13], 32'hFFFF_80F1);
    run_instr(enc_ld(3'b101, 5'd14, 5'd1, 12'd2), "R4", 3);
    check(rf[14] == 32'h0000_80F1, "R6", "lhu upper", rf[14], 32'h0000_80F1);
    run_instr(enc_ld(3'b001, 5'd15, 5'd1, 12'd0), "R4", 3);
    check(rf[15] == 32'h0000_7F22, "R6", "lh lower positive", rf[15], 32'h0000_7F22);
  endtask

  task automatic t_stores;
    run_instr(enc_st(3'b000, 5'd6, 5'd2, 12'd1), "R7", 3);
    check(mem[40] == 32'h1122_AB44, "R7", "sb lane1", mem[40], 32'h1122_AB44);
    check(!last_rf_we && last_mem_we, "R7", "sb write flags", {30'h0, last_rf_we, last_mem_we}, 32'h1);
    run_instr(enc_st(3'b001, 5'd7, 5'd2, 12'd2), "R7", 3);
    check(mem[40] == 32'hBEEF_AB44, "R7", "sh upper half", mem[40], 32'hBEEF_AB44);
    run_instr(enc_st(3'b010, 5'd8, 5'd3, 12'hFF4), "R5", 3);
    check(mem[41] == 32'hCAFE_F00D, "R7", "sw negative offset", mem[41], 32'hCAFE_F00D);
    check(mem[40] == 32'hBEEF_AB44, "R7", "neighbour word kept", mem[40], 32'hBEEF_AB44);
  endtask

  task automatic t_x0;
    run_instr(enc_ld(3'b010, 5'd0, 5'd1, 12'd0), "R8", 3);
    check(rf[0] == 32'h0 && !last_rf_we, "R8", "x0 untouched", rf[0], 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0000_0013;
    for (int i = 0; i < 32; i++) rf[i] = 32'h0;
    mem[0]  = 32'h0000_0000;
    mem[33] = 32'h8BAD_F00D;   // 0x84
    mem[36] = 32'h80F1_7F22;   // 0x90
    mem[40] = 32'h1122_3344;   // 0xA0
    mem[41] = 32'h0000_0000;   // 0xA4
    rf[1] = 32'h90; rf[2] = 32'hA0; rf[3] = 32'hB0; rf[4] = 32'hA0;
    rf[6] = 32'h0000_55AB; rf[7] = 32'h1234_BEEF; rf[8] = 32'hCAFE_F00D;
    rf[9] = 32'h80;
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_unlisted_funct3();
    t_word_loads();
    t_byte_loads();
    t_half_loads();
    t_stores();
    t_x0();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_failed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
    $finish;
  end
endmodule